// File: doc/BRIEF.md
# Programmable Per-Line Edge Detector Array

This block watches a wide bank of single-bit input lines and raises a one-cycle event on every line where a programmed transition occurred. Each line is configured on its own: a 2-bit selector chooses rising, falling or both-edge detection, and a 1-bit mask decides whether that line may report at all. A global enable bit gates the whole array.

All settings live in 32-bit words reached through a plain register port (write enable, address, write data, combinational read data). Selector words come first in the address map, 16 lines per word; mask words follow, 32 lines per word; the enable word comes last. Outputs are the registered per-line event vector and a registered single-bit "some line fired" pulse.

Inputs are sampled once, and each sample is compared with the one before it. A level change presented before rising edge N is reported during the cycle after rising edge N+1.

Top module: `edge_line_monitor`

## Requirements
- R1: An input change presented before clock edge N shows on `events_o` after edge N+1 and lasts exactly one cycle; with steady inputs `events_o` stays zero.
- R2: Selector code 0 detects a 0-to-1 transition, code 1 a 1-to-0 transition, and code 2 either transition.
- R3: When a selector word is written, a 2-bit field whose written value is 3 keeps its old value, while the other fields of that word take the written value; a stored field never holds 3.
- R4: Mask bit 1 passes the line's event; mask bit 0 forces it to zero.
- R5: `any_o` equals the OR of `events_o` in every cycle.
- R6: The enable word is at address NUM_LINES/16+NUM_LINES/32, and only its bit 0 is stored. While that bit is 0 no event or `any_o` is produced. It reads back as that single bit.
- R7: Line i's selector sits at address i/16, bits 2*(i mod 16)+1:2*(i mod 16). Its mask bit sits at address NUM_LINES/16 + i/32, bit i mod 32.
- R8: An address above the enable word, which stands for line indices NUM_LINES and above, is rejected: a write there changes no stored word, and a read there returns 0.
- R9: Reset clears all selector, mask and enable words. The previous-sample register loads the current inputs, so no event follows reset while the inputs are steady.
- R10: Selector, mask and enable words read back as last accepted, in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lines_i | input | NUM_LINES | Monitored lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| events_o | output | NUM_LINES | Per-line registered event |
| any_o | output | 1 | Registered OR of all events |

## Verification
A configuration write and an edge being judged can land in the same cycle. The bench provokes this by changing the inputs and writing a mask word before the same clock edge. Because the comparison runs one cycle after sampling, the newly written mask must govern that edge. It checks this both ways: opening a closed mask lets the edge through, and closing an open mask suppresses it.

// File: rtl/elm_pkg.sv
package elm_pkg;
  localparam int WORD_W         = 32;
  localparam int FIELDS_PER_WORD = 16;
  localparam int LINES_PER_MASK = 32;

  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_BOTH = 2'd2,
    SEL_RSVD = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/elm_regs.sv
module elm_regs
  import elm_pkg::*;
#(
  parameter int NUM_LINES = 256,
  parameter int AW        = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [WORD_W-1:0]      wdata,
  output logic [WORD_W-1:0]      rdata,
  output logic [2*NUM_LINES-1:0] ctrl_flat,
  output logic [NUM_LINES-1:0]   mask_flat,
  output logic                   enable
);
  localparam int CW        = NUM_LINES / FIELDS_PER_WORD;
  localparam int MW        = NUM_LINES / LINES_PER_MASK;
  localparam int MASK_BASE = CW;
  localparam int ENA_ADDR  = CW + MW;

  logic [WORD_W-1:0] ctrl_q [CW];
  logic [WORD_W-1:0] mask_q [MW];
  logic              ena_q;

  // selector words: a reserved code leaves its field untouched
  for (genvar w = 0; w < CW; w++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[w] <= '0;
      end else if (wr_en && addr == AW'(w)) begin
        for (int f = 0; f < FIELDS_PER_WORD; f++) begin
          if (wdata[2*f +: 2] != SEL_RSVD) ctrl_q[w][2*f +: 2] <= wdata[2*f +: 2];
        end
      end
    end
    assign ctrl_flat[w*WORD_W +: WORD_W] = ctrl_q[w];
  end

  for (genvar m = 0; m < MW; m++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) mask_q[m] <= '0;
      else if (wr_en && addr == AW'(MASK_BASE + m)) mask_q[m] <= wdata;
    end
    assign mask_flat[m*WORD_W +: WORD_W] = mask_q[m];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ena_q <= 1'b0;
    else if (wr_en && addr == AW'(ENA_ADDR)) ena_q <= wdata[0];
  end
  assign enable = ena_q;

  always_comb begin
    rdata = '0;
    for (int w = 0; w < CW; w++) begin
      if (addr == AW'(w)) rdata = ctrl_q[w];
    end
    for (int m = 0; m < MW; m++) begin
      if (addr == AW'(MASK_BASE + m)) rdata = mask_q[m];
    end
    if (addr == AW'(ENA_ADDR)) rdata = {{(WORD_W-1){1'b0}}, ena_q};
  end
endmodule

// File: rtl/elm_sampler.sv
module elm_sampler #(
  parameter int NUM_LINES = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_LINES-1:0] cur_q,
  output logic [NUM_LINES-1:0] prev_q
);
  // during reset both stages follow the inputs: no false edge afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= lines_i;
      prev_q <= lines_i;
    end else begin
      cur_q  <= lines_i;
      prev_q <= cur_q;
    end
  end
endmodule

// File: rtl/elm_classify.sv
module elm_classify
  import elm_pkg::*;
(
  input  logic       cur,
  input  logic       prev,
  input  logic [1:0] sel,
  output logic       hit
);
  always_comb begin
    case (edge_sel_e'(sel))
      SEL_RISE: hit = cur & ~prev;
      SEL_FALL: hit = ~cur & prev;
      SEL_BOTH: hit = cur ^ prev;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/edge_line_monitor.sv
module edge_line_monitor
  import elm_pkg::*;
#(
  parameter int NUM_LINES = 256,
  parameter int AW        = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 reg_we_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  output logic [NUM_LINES-1:0] events_o,
  output logic                 any_o
);
  logic [2*NUM_LINES-1:0] ctrl_flat;
  logic [NUM_LINES-1:0]   mask_flat;
  logic                   ena;
  logic [NUM_LINES-1:0]   samp_q;
  logic [NUM_LINES-1:0]   prev_q;
  logic [NUM_LINES-1:0]   hit;
  logic [NUM_LINES-1:0]   gated;

  elm_regs #(.NUM_LINES(NUM_LINES), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .rdata(reg_rdata_o),
    .ctrl_flat(ctrl_flat), .mask_flat(mask_flat), .enable(ena)
  );

  elm_sampler #(.NUM_LINES(NUM_LINES)) samp_i (
    .clk(clk), .rst_n(rst_n), .lines_i(lines_i),
    .cur_q(samp_q), .prev_q(prev_q)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    elm_classify cls_i (
      .cur(samp_q[i]), .prev(prev_q[i]),
      .sel(ctrl_flat[2*i +: 2]), .hit(hit[i])
    );
  end

  assign gated = hit & mask_flat & {NUM_LINES{ena}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      events_o <= '0;
      any_o    <= 1'b0;
    end else begin
      events_o <= gated;
      any_o    <= |gated;
    end
  end
endmodule

// File: rtl/elm_checker.sv
module elm_checker #(
  parameter int NUM_LINES = 256
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2*NUM_LINES-1:0] ctrl_flat,
  input logic [NUM_LINES-1:0]   mask_flat,
  input logic                   ena,
  input logic [NUM_LINES-1:0]   samp_q,
  input logic [NUM_LINES-1:0]   prev_q,
  input logic [NUM_LINES-1:0]   events_o,
  input logic                   any_o
);
  localparam logic [2*NUM_LINES-1:0] LOW_BITS = {NUM_LINES{2'b01}};

  // R1: an event needs a sample difference one cycle earlier
  a_r1_event_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    (events_o & ~$past(samp_q ^ prev_q)) == '0);

  // R3: no stored selector field holds the reserved code
  a_r3_no_rsvd_field: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_flat & (ctrl_flat >> 1) & LOW_BITS) == '0);

  // R4: a line masked in the previous cycle cannot report
  a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (events_o & ~$past(mask_flat)) == '0);

  // R5: summary pulse matches the vector
  a_r5_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
    any_o == (|events_o));

  // R6: disabled array stays silent next cycle
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |=> (events_o == '0 && !any_o));

  // R9: nothing reported right after reset
  a_r9_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (events_o == '0));
endmodule

bind edge_line_monitor elm_checker #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_flat(ctrl_flat), .mask_flat(mask_flat),
  .ena(ena), .samp_q(samp_q), .prev_q(prev_q),
  .events_o(events_o), .any_o(any_o)
);

// File: tb/edge_line_monitor_tb_top.sv
`timescale 1ns/1ps
module edge_line_monitor_tb_top;
  localparam int N  = 32;
  localparam int AW = 4;
  localparam int A_MASK = 2;   // N/16
  localparam int A_ENA  = 3;   // N/16 + N/32

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lines = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  events;
  logic          any;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  edge_line_monitor #(.NUM_LINES(N), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .events_o(events), .any_o(any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk);
    addr = AW'(a);
    #1 chk(tag, rdata, exp);
  endtask

  // drive lines, then check the two following cycles (R1 latency)
  task automatic edge_chk(input string tag, input logic [N-1:0] v, input logic [N-1:0] exp);
    @(negedge clk);
    lines = v;
    @(negedge clk);
    chk({tag, " early"}, events, '0);
    @(negedge clk);
    chk(tag, events, exp);
    chk({tag, " any"}, {31'b0, any}, {31'b0, |exp});
    @(negedge clk);
    chk({tag, " R1 one-cycle"}, events, '0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lines = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd("R9 ctrl0", 0, 0);
    rd("R9 ctrl1", 1, 0);
    rd("R9 mask", A_MASK, 0);
    rd("R9 ena", A_ENA, 0);
    wr(0, 32'hAAAA_AAAA); wr(1, 32'hAAAA_AAAA);
    wr(A_MASK, 32'hFFFF_FFFF); wr(A_ENA, 1);
    repeat (3) @(negedge clk);
    chk("R9 no false edge", events, '0);
    // R10 readback and R6 enable single bit
    rd("R10 ctrl0", 0, 32'hAAAA_AAAA);
    wr(A_ENA, 32'hFFFF_FFFF);
    rd("R6 ena readback", A_ENA, 1);
    // R3 reserved codes
    wr(0, 32'hFFFF_FFFF);
    rd("R3 all reserved", 0, 32'hAAAA_AAAA);
    wr(0, 32'h0000_0007);
    rd("R3 mixed", 0, 32'h0000_0006);
    // R8 out of range
    for (int a = A_ENA + 1; a < 16; a++) begin
      wr(a, 32'h5555_5555);
      rd("R8 read zero", a, 0);
    end
    rd("R8 ctrl0 kept", 0, 32'h0000_0006);
    rd("R8 ctrl1 kept", 1, 32'hAAAA_AAAA);
    rd("R8 mask kept", A_MASK, 32'hFFFF_FFFF);
    rd("R8 ena kept", A_ENA, 1);
    // settle lines low
    lines = '0;
    repeat (4) @(negedge clk);
    // R2 R7 R4 sweep: each line, each code, only that line unmasked
    for (int l = 0; l < N; l++) begin
      for (int m = 0; m < 3; m++) begin
        logic [N-1:0] bit_l;
        bit_l = N'(1) << l;
        wr(l / 16, 32'(m) << (2 * (l % 16)));
        wr(1 - l / 16, 32'h0);
        wr(A_MASK, bit_l);
        edge_chk("R2 R7 rise", bit_l | ~bit_l, (m == 0 || m == 2) ? bit_l : '0);
        edge_chk("R2 R7 fall", '0, (m == 1 || m == 2) ? bit_l : '0);
      end
    end
    // R4 mask pattern with toggle everywhere
    wr(0, 32'hAAAA_AAAA); wr(1, 32'hAAAA_AAAA);
    wr(A_MASK, 32'h0F0F_00FF);
    edge_chk("R4 pattern up", 32'h1234_5678, 32'h1234_5678 & 32'h0F0F_00FF);
    edge_chk("R4 pattern down", 32'h0, 32'h1234_5678 & 32'h0F0F_00FF);
    // R6 disable
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_ENA, 0);
    edge_chk("R6 disabled up", 32'hDEAD_BEEF, 32'h0);
    edge_chk("R6 disabled down", 32'h0, 32'h0);
    wr(A_ENA, 1);
    edge_chk("R6 re-enabled", 32'h8000_0001, 32'h8000_0001);
    edge_chk("R6 re-enabled down", 32'h0, 32'h8000_0001);
    // same-cycle mask write and edge: new mask governs
    wr(A_MASK, 32'h0);
    @(negedge clk);
    lines = 32'h0000_0010; we = 1'b1; addr = AW'(A_MASK); wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
    chk("R4 same-cycle open", events, 32'h0000_0010);
    @(negedge clk);
    lines = 32'h0; we = 1'b1; addr = AW'(A_MASK); wdata = 32'h0;
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
    chk("R4 same-cycle close", events, 32'h0);
    chk("R5 same-cycle close any", {31'b0, any}, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule